// File: doc/BRIEF.md
# Link Receive Frame Filter

This block sits on the receive side of a link bridge. It takes a 32-bit word stream in which a start flag marks each frame header, and a separate flag marks dead cycles. It parses each header, then throws away idle frames and dead cycles. Every other frame goes, header and payload in arrival order, into one of two queues: one for control traffic and one for data traffic. A type mask chosen at build time sets which frame types count as control.

Each queue drives a valid/ready output stream. A last marker flags the final word of each frame. Each queue also produces a ready indication for the link peer, and that indication drops while the free space is too small to absorb the words still in flight during the peer's response latency. If a word arrives anyway when its queue is full, the block drops that word and the rest of its frame, and sets a sticky overflow flag.

Top module: `link_rx_filter`

## Requirements
- R1: A frame whose header type field (bits 27:24) is 0 is idle; neither its header nor its payload words are written to either queue.
- R2: A word presented with `in_dead_i` high is discarded, whatever `in_sof_i` says. It does not count toward the payload of the frame in progress.
- R3: A non-idle frame goes to the control queue when bit `type` of `CTRL_MASK` is 1, and to the data queue otherwise. Words leave each queue in the order they arrived.
- R4: The payload word count is header bits 7:0. The header and the next that many live non-start words form the frame, and every one of them is stored unmodified. The stored last marker is 1 only on the frame's final word.
- R5: A header whose length field is 0 is stored as a single entry with its last marker set.
- R6: `crdy_o` (control queue) and `drdy_o` (data queue) are 0 while that queue's free entries are at or below `LATENCY_WORDS`, and 1 otherwise.
- R7: A word routed to a queue that holds `DEPTH` entries at that clock edge is dropped, together with every later word of the same frame. The queue's overflow flag then rises and stays high until reset.
- R8: Live words arriving outside a frame (no start flag, no payload still expected) are discarded. A start flag in the middle of a frame abandons that frame and begins a new one.
- R9: After reset both queues are empty, both output valids and both overflow flags are 0, and both peer ready outputs are 1.
- R10: An entry leaves its queue only on a cycle where its valid and ready are both high. While valid is high and ready is low, the head word and its last marker stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input word present |
| in_sof_i | input | 1 | Word is a frame header |
| in_dead_i | input | 1 | Word is a dead cycle |
| in_data_i | input | 32 | Input word |
| ctrl_valid_o | output | 1 | Control queue head valid |
| ctrl_ready_i | input | 1 | Control consumer accepts head |
| ctrl_data_o | output | 32 | Control head word |
| ctrl_last_o | output | 1 | Control head ends its frame |
| data_valid_o | output | 1 | Data queue head valid |
| data_ready_i | input | 1 | Data consumer accepts head |
| data_data_o | output | 32 | Data head word |
| data_last_o | output | 1 | Data head ends its frame |
| crdy_o | output | 1 | Peer may send control frames |
| drdy_o | output | 1 | Peer may send data frames |
| ctrl_ovf_o | output | 1 | Sticky control queue overflow |
| data_ovf_o | output | 1 | Sticky data queue overflow |

## Verification
The bench builds the block with `DEPTH` 8, `LATENCY_WORDS` 3 and `CTRL_MASK` 16'h000E, so types 1 to 3 are control. With a shallow queue, a single 13-word frame against a stalled consumer overflows it, and the ready threshold falls at the fifth stored entry. Overflow, truncated frames and the threshold edge therefore come up often, under both directed and random traffic. Random frame lengths of 0 to 6 mix header-only entries, dead cycles and stray words with consumers that stall at random.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  localparam int WORD_W   = 32;
  localparam int TYPE_LSB = 24;
  localparam int TYPE_W   = 4;
  localparam int LEN_LSB  = 0;
  localparam int LEN_W    = 8;
  localparam int ENTRY_W  = WORD_W + 1;  // {last, word}

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_IDLE = 2'd1,
    DST_CTRL = 2'd2,
    DST_DATA = 2'd3
  } dst_e;
endpackage

// File: rtl/lrf_parser.sv
module lrf_parser
  import lrf_pkg::*;
#(
  parameter logic [15:0] CTRL_MASK = 16'h000E
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               sof_i,
  input  logic               dead_i,
  input  logic [WORD_W-1:0]  data_i,
  input  logic [1:0]         full_i,     // [0] ctrl, [1] data
  output logic [1:0]         wr_o,
  output logic [1:0]         ovf_set_o,
  output logic [ENTRY_W-1:0] wr_entry_o
);
  dst_e             dst_q, hdr_dst, cur_dst;
  logic [LEN_W-1:0] rem_q, hdr_len;
  logic [TYPE_W-1:0] hdr_type;
  logic             drop_q, live, hdr, body, want, is_last, tgt_full;

  assign live     = valid_i & ~dead_i;
  assign hdr      = live & sof_i;
  assign body     = live & ~sof_i & (rem_q != '0);
  assign hdr_type = data_i[TYPE_LSB +: TYPE_W];
  assign hdr_len  = data_i[LEN_LSB +: LEN_W];

  always_comb begin
    if (hdr_type == '0)          hdr_dst = DST_IDLE;
    else if (CTRL_MASK[hdr_type]) hdr_dst = DST_CTRL;
    else                         hdr_dst = DST_DATA;
  end

  always_comb begin
    cur_dst = hdr ? hdr_dst : dst_q;
    is_last = hdr ? (hdr_len == '0) : (rem_q == LEN_W'(1));
    if (hdr) want = (hdr_dst == DST_CTRL) | (hdr_dst == DST_DATA);
    else     want = body & ~drop_q & ((dst_q == DST_CTRL) | (dst_q == DST_DATA));
    tgt_full = (cur_dst == DST_CTRL) ? full_i[0] : full_i[1];
  end

  always_comb begin
    wr_o      = '0;
    ovf_set_o = '0;
    if (want) begin
      if (cur_dst == DST_CTRL) begin
        wr_o[0]      = ~full_i[0];
        ovf_set_o[0] = full_i[0];
      end else begin
        wr_o[1]      = ~full_i[1];
        ovf_set_o[1] = full_i[1];
      end
    end
  end

  assign wr_entry_o = {is_last, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q  <= DST_NONE;
      rem_q  <= '0;
      drop_q <= 1'b0;
    end else if (hdr) begin
      dst_q  <= hdr_dst;
      rem_q  <= hdr_len;
      drop_q <= want & tgt_full;
    end else if (body) begin
      rem_q <= rem_q - LEN_W'(1);
      if (want && tgt_full) drop_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lrf_fifo.sv
module lrf_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 33,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [W-1:0]     wr_data_i,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [W-1:0]     rd_data_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  assign rd_valid_o = (cnt_q != '0);
  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign rd_data_o  = mem[rp_q];
  assign cnt_o      = cnt_q;
  assign pop        = rd_valid_o & rd_ready_i;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) wp_q <= wp_q + PTR_W'(1);
      if (pop)  rp_q <= rp_q + PTR_W'(1);
      case ({wr_i, pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/lrf_rdy_gen.sv
module lrf_rdy_gen #(
  parameter int DEPTH = 64,
  parameter int LAT   = 12,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             rdy_o
);
  logic [CNT_W-1:0] free;
  assign free  = CNT_W'(DEPTH) - cnt_i;
  assign rdy_o = (free > CNT_W'(LAT));
endmodule

// File: rtl/link_rx_filter.sv
module link_rx_filter
  import lrf_pkg::*;
#(
  parameter int          DEPTH         = 64,
  parameter int          LATENCY_WORDS = 12,
  parameter logic [15:0] CTRL_MASK     = 16'h000E,
  localparam int         CNT_W         = $clog2(DEPTH) + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic        in_sof_i,
  input  logic        in_dead_i,
  input  logic [31:0] in_data_i,
  output logic        ctrl_valid_o,
  input  logic        ctrl_ready_i,
  output logic [31:0] ctrl_data_o,
  output logic        ctrl_last_o,
  output logic        data_valid_o,
  input  logic        data_ready_i,
  output logic [31:0] data_data_o,
  output logic        data_last_o,
  output logic        crdy_o,
  output logic        drdy_o,
  output logic        ctrl_ovf_o,
  output logic        data_ovf_o
);
  logic [1:0]         q_wr, q_full, q_ovf_set, q_ready, q_valid, q_rdy;
  logic [ENTRY_W-1:0] wr_entry;
  logic [ENTRY_W-1:0] q_head [2];
  logic [CNT_W-1:0]   q_cnt  [2];
  logic               q_ovf_q [2];
  logic [CNT_W-1:0]   ctrl_cnt, data_cnt;

  lrf_parser #(.CTRL_MASK(CTRL_MASK)) u_parser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (in_valid_i),
    .sof_i      (in_sof_i),
    .dead_i     (in_dead_i),
    .data_i     (in_data_i),
    .full_i     (q_full),
    .wr_o       (q_wr),
    .ovf_set_o  (q_ovf_set),
    .wr_entry_o (wr_entry)
  );

  assign q_ready = {data_ready_i, ctrl_ready_i};

  for (genvar g = 0; g < 2; g++) begin : g_q
    lrf_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (q_wr[g]),
      .wr_data_i  (wr_entry),
      .rd_valid_o (q_valid[g]),
      .rd_ready_i (q_ready[g]),
      .rd_data_o  (q_head[g]),
      .full_o     (q_full[g]),
      .cnt_o      (q_cnt[g])
    );

    lrf_rdy_gen #(.DEPTH(DEPTH), .LAT(LATENCY_WORDS)) u_rdy (
      .cnt_i (q_cnt[g]),
      .rdy_o (q_rdy[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           q_ovf_q[g] <= 1'b0;
      else if (q_ovf_set[g]) q_ovf_q[g] <= 1'b1;
    end
  end

  assign ctrl_valid_o = q_valid[0];
  assign ctrl_data_o  = q_head[0][WORD_W-1:0];
  assign ctrl_last_o  = q_head[0][WORD_W];
  assign data_valid_o = q_valid[1];
  assign data_data_o  = q_head[1][WORD_W-1:0];
  assign data_last_o  = q_head[1][WORD_W];
  assign crdy_o       = q_rdy[0];
  assign drdy_o       = q_rdy[1];
  assign ctrl_ovf_o   = q_ovf_q[0];
  assign data_ovf_o   = q_ovf_q[1];
  assign ctrl_cnt     = q_cnt[0];
  assign data_cnt     = q_cnt[1];
endmodule

// File: rtl/lrf_checker.sv
module lrf_checker #(
  parameter int DEPTH = 64,
  parameter int LAT   = 12,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_sof_i,
  input logic             in_dead_i,
  input logic [31:0]      in_data_i,
  input logic             ctrl_valid_o,
  input logic             ctrl_ready_i,
  input logic [31:0]      ctrl_data_o,
  input logic             ctrl_last_o,
  input logic             data_valid_o,
  input logic             data_ready_i,
  input logic [31:0]      data_data_o,
  input logic             data_last_o,
  input logic             crdy_o,
  input logic             drdy_o,
  input logic             ctrl_ovf_o,
  input logic             data_ovf_o,
  input logic [CNT_W-1:0] ctrl_cnt,
  input logic [CNT_W-1:0] data_cnt
);
  p_idle_nowrite_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_sof_i && !in_dead_i && in_data_i[27:24] == 4'h0)
    |=> (ctrl_cnt <= $past(ctrl_cnt)) && (data_cnt <= $past(data_cnt)));

  p_dead_nowrite_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_dead_i)
    |=> (ctrl_cnt <= $past(ctrl_cnt)) && (data_cnt <= $past(data_cnt)));

  p_crdy_thresh_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_cnt >= CNT_W'(DEPTH - LAT)) |-> !crdy_o);

  p_drdy_thresh_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_cnt < CNT_W'(DEPTH - LAT)) |-> drdy_o);

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_cnt <= CNT_W'(DEPTH)) && (data_cnt <= CNT_W'(DEPTH)));

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_ovf_o || data_ovf_o)
    |=> (ctrl_ovf_o || !$past(ctrl_ovf_o)) && (data_ovf_o || !$past(data_ovf_o)));

  p_ctrl_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_valid_o && !ctrl_ready_i)
    |=> ctrl_valid_o && $stable(ctrl_data_o) && $stable(ctrl_last_o));

  p_data_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && !data_ready_i)
    |=> data_valid_o && $stable(data_data_o) && $stable(data_last_o));
endmodule

bind link_rx_filter lrf_checker #(.DEPTH(DEPTH), .LAT(LATENCY_WORDS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_sof_i     (in_sof_i),
  .in_dead_i    (in_dead_i),
  .in_data_i    (in_data_i),
  .ctrl_valid_o (ctrl_valid_o),
  .ctrl_ready_i (ctrl_ready_i),
  .ctrl_data_o  (ctrl_data_o),
  .ctrl_last_o  (ctrl_last_o),
  .data_valid_o (data_valid_o),
  .data_ready_i (data_ready_i),
  .data_data_o  (data_data_o),
  .data_last_o  (data_last_o),
  .crdy_o       (crdy_o),
  .drdy_o       (drdy_o),
  .ctrl_ovf_o   (ctrl_ovf_o),
  .data_ovf_o   (data_ovf_o),
  .ctrl_cnt     (ctrl_cnt),
  .data_cnt     (data_cnt)
);

// File: tb/link_rx_filter_tb.sv
module link_rx_filter_tb;
  localparam int          DEPTH = 8;
  localparam int          LAT   = 3;
  localparam logic [15:0] MASK  = 16'h000E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_dead = 1'b0;
  logic [31:0] in_data = '0;
  logic        c_ready = 1'b0, d_ready = 1'b0;
  logic        c_valid, c_last, d_valid, d_last, crdy, drdy, c_ovf, d_ovf;
  logic [31:0] c_data, d_data;

  always #5 clk = ~clk;

  link_rx_filter #(.DEPTH(DEPTH), .LATENCY_WORDS(LAT), .CTRL_MASK(MASK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_sof_i(in_sof), .in_dead_i(in_dead), .in_data_i(in_data),
    .ctrl_valid_o(c_valid), .ctrl_ready_i(c_ready), .ctrl_data_o(c_data), .ctrl_last_o(c_last),
    .data_valid_o(d_valid), .data_ready_i(d_ready), .data_data_o(d_data), .data_last_o(d_last),
    .crdy_o(crdy), .drdy_o(drdy), .ctrl_ovf_o(c_ovf), .data_ovf_o(d_ovf)
  );

  int checks = 0, errors = 0;
  int c_pops = 0, d_pops = 0;
  int rmode = 0;  // 0 stall, 1 random, 2 always ready

  // reference model
  logic [32:0] cq[$];
  logic [32:0] dq[$];
  int  m_rem = 0, m_dst = 0;  // dst: 0 none, 1 idle, 2 ctrl, 3 data
  bit  m_drop = 0, m_covf = 0, m_dovf = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    cq.delete(); dq.delete();
    m_rem = 0; m_dst = 0; m_drop = 0; m_covf = 0; m_dovf = 0;
  endtask

  task automatic compare();
    chk(c_valid == (cq.size() != 0), "R10", "ctrl valid", c_valid, cq.size() != 0);
    chk(d_valid == (dq.size() != 0), "R10", "data valid", d_valid, dq.size() != 0);
    if (cq.size() != 0) begin
      chk(c_data == cq[0][31:0], "R3", "ctrl word", c_data, cq[0][31:0]);
      chk(c_last == cq[0][32], "R4", "ctrl last", c_last, cq[0][32]);
    end
    if (dq.size() != 0) begin
      chk(d_data == dq[0][31:0], "R3", "data word", d_data, dq[0][31:0]);
      chk(d_last == dq[0][32], "R4", "data last", d_last, dq[0][32]);
    end
    chk(crdy == ((DEPTH - cq.size()) > LAT), "R6", "crdy", crdy, (DEPTH - cq.size()) > LAT);
    chk(drdy == ((DEPTH - dq.size()) > LAT), "R6", "drdy", drdy, (DEPTH - dq.size()) > LAT);
    chk(c_ovf == m_covf, "R7", "ctrl ovf", c_ovf, m_covf);
    chk(d_ovf == m_dovf, "R7", "data ovf", d_ovf, m_dovf);
  endtask

  task automatic model_step(logic v, logic s, logic d, logic [31:0] w, logic cr, logic dr);
    bit cfull, dfull, popc, popd, pushc, pushd, last, tgt;
    cfull = (cq.size() == DEPTH);
    dfull = (dq.size() == DEPTH);
    popc = cr && cq.size() != 0;
    popd = dr && dq.size() != 0;
    pushc = 0; pushd = 0; last = 0; tgt = 0;
    if (v && !d) begin
      if (s) begin
        m_rem = int'(w[7:0]);
        m_drop = 0;
        if (w[27:24] == 4'h0) m_dst = 1;
        else if (MASK[w[27:24]]) m_dst = 2;
        else m_dst = 3;
        last = (m_rem == 0);
        tgt = (m_dst != 1);
      end else if (m_rem > 0) begin
        last = (m_rem == 1);
        m_rem--;
        tgt = (m_dst >= 2) && !m_drop;
      end
      if (tgt) begin
        if (m_dst == 2) begin
          if (cfull) begin m_covf = 1; m_drop = 1; end else pushc = 1;
        end else begin
          if (dfull) begin m_dovf = 1; m_drop = 1; end else pushd = 1;
        end
      end
    end
    if (popc) void'(cq.pop_front());
    if (popd) void'(dq.pop_front());
    if (pushc) cq.push_back({last, w});
    if (pushd) dq.push_back({last, w});
  endtask

  task automatic step(logic v, logic s, logic d, logic [31:0] w);
    logic cr, dr;
    @(negedge clk);
    compare();
    case (rmode)
      0: begin cr = 0; dr = 0; end
      1: begin cr = ($urandom_range(9) < 7); dr = ($urandom_range(9) < 6); end
      default: begin cr = 1; dr = 1; end
    endcase
    if (c_valid && cr) c_pops++;
    if (d_valid && dr) d_pops++;
    in_valid = v; in_sof = s; in_dead = d; in_data = w;
    c_ready = cr; d_ready = dr;
    model_step(v, s, d, w, cr, dr);
  endtask

  task automatic idle_step();
    step(1'b0, 1'b0, 1'b0, $urandom);
  endtask

  function automatic logic [31:0] mk_hdr(logic [3:0] ty, logic [7:0] len);
    logic [31:0] r;
    r = $urandom;
    r[27:24] = ty;
    r[7:0] = len;
    return r;
  endfunction

  task automatic send_frame(logic [3:0] ty, int len, int dead_pct);
    step(1'b1, 1'b1, 1'b0, mk_hdr(ty, 8'(len)));
    for (int i = 0; i < len; i++) begin
      while ($urandom_range(99) < dead_pct) step(1'b1, $urandom_range(1), 1'b1, $urandom);
      step(1'b1, 1'b0, 1'b0, $urandom);
    end
  endtask

  task automatic drain();
    int saved;
    saved = rmode;
    rmode = 2;
    c_pops = 0; d_pops = 0;
    for (int i = 0; i < 4 * DEPTH; i++) idle_step();
    rmode = saved;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    in_valid = 0; c_ready = 0; d_ready = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(!c_valid && !d_valid, "R9", "valids after reset", {c_valid, d_valid}, 0);
    chk(crdy && drdy, "R9", "readies after reset", {crdy, drdy}, 3);
    chk(!c_ovf && !d_ovf, "R9", "ovf after reset", {c_ovf, d_ovf}, 0);

    // R1: idle frame leaves both queues empty
    rmode = 0;
    send_frame(4'h0, 3, 0);
    drain();
    chk(c_pops == 0 && d_pops == 0, "R1", "entries from idle frame", c_pops + d_pops, 0);

    // R2: dead cycles, one carrying a start flag, inside a control frame
    rmode = 0;
    step(1'b1, 1'b1, 1'b0, mk_hdr(4'h1, 8'd2));
    step(1'b1, 1'b1, 1'b1, mk_hdr(4'h2, 8'd0));
    step(1'b1, 1'b0, 1'b0, 32'hA5A5_0001);
    step(1'b1, 1'b0, 1'b1, 32'hDEAD_DEAD);
    step(1'b1, 1'b0, 1'b0, 32'hA5A5_0002);
    drain();
    chk(c_pops == 3, "R2", "ctrl entries with dead cycles", c_pops, 3);

    // R5: header-only data frame
    rmode = 0;
    send_frame(4'h5, 0, 0);
    drain();
    chk(d_pops == 1, "R5", "header-only entries", d_pops, 1);

    // R8: stray words, then a frame cut short by a new header
    rmode = 0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, $urandom);
    step(1'b1, 1'b1, 1'b0, mk_hdr(4'h3, 8'd3));
    step(1'b1, 1'b0, 1'b0, 32'h1111_0001);
    send_frame(4'h2, 1, 0);
    drain();
    chk(c_pops == 4, "R8", "ctrl entries after stray and restart", c_pops, 4);

    // R7: overflow of the data queue
    rmode = 0;
    send_frame(4'h9, 12, 0);
    idle_step();
    chk(d_ovf == 1'b1, "R7", "data ovf raised", d_ovf, 1);
    chk(drdy == 1'b0, "R6", "drdy low when full", drdy, 0);
    chk(c_ovf == 1'b0, "R7", "ctrl ovf untouched", c_ovf, 0);
    drain();
    chk(d_pops == DEPTH, "R7", "stored words before drop", d_pops, DEPTH);
    chk(d_ovf == 1'b1, "R7", "data ovf sticky", d_ovf, 1);

    // R6: threshold edge on the control queue
    do_reset();
    rmode = 0;
    send_frame(4'h1, 3, 0);
    idle_step();
    chk(crdy == 1'b1, "R6", "crdy with 4 free", crdy, 1);
    send_frame(4'h2, 0, 0);
    idle_step();
    chk(crdy == 1'b0, "R6", "crdy with 3 free", crdy, 0);
    drain();

    // random traffic
    do_reset();
    for (int f = 0; f < 400; f++) begin
      rmode = (f % 50 < 10) ? 0 : 1;
      if ($urandom_range(9) == 0) step(1'b1, 1'b0, 1'b0, $urandom);
      if ($urandom_range(3) == 0) idle_step();
      send_frame(4'($urandom_range(15)), $urandom_range(6), 15);
    end
    drain();
    chk(!c_valid && !d_valid, "R10", "queues empty after drain", {c_valid, d_valid}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule